// File: doc/BRIEF.md
# Reusable Block Table

This block keeps a small per-core pool of memory blocks that were found dead by reference counting, so the allocator can hand them out again instead of carving fresh memory. Each dead block arrives as an insertion carrying its address and a size class. The allocator asks for memory by byte size; the table rounds the size up to one of its classes and answers with the most recently stored block of that class, or with address zero when it has nothing suitable, in which case the allocator falls back to its own bump-pointer path. A returned block leaves the table, so it is given out only once.

When a class runs low, the table asks a next-level table for more blocks of that class through a request/response port, one request at a time. Insertions use a valid/ready stream whose ready is always high: an insertion into a full class is discarded and counted rather than stalled. Refill requests are held stable until the next level takes them. Refill responses are back-pressured only in the cycle where an insertion targets the same class; the insertion wins. Queries are accepted every cycle and produce one response in the following cycle, which the requester must take.

Top module: `reuse_block_table`

## Requirements
- R1: A query is answered one cycle later with rsp_valid high; sizes up to 16 bytes use class 0, 17 to 32 class 1, 33 to 64 class 2, 65 to 128 class 3 (boundaries inclusive), and rsp_valid stays low in cycles that follow no query.
- R2: A query whose class holds no block returns address 0.
- R3: A query larger than 128 bytes returns address 0 and removes nothing from any class.
- R4: Within a class, blocks are returned last-in first-out, each block exactly once.
- R5: An insertion and a query for the same class in the same cycle return the inserted address, and that class's occupancy is unchanged.
- R6: ins_ready is always 1; an insertion into a class already holding 8 blocks is discarded, drop_count rises by exactly 1, and the stored blocks are unaffected.
- R7: When no refill is outstanding and some class holds fewer than 2 blocks, ref_req_valid rises with ref_req_class set to the lowest such class, and both stay unchanged until ref_req_ready is seen.
- R8: Between the request handshake and the response handshake, ref_req_valid stays low.
- R9: A refill response with a nonzero address is stored into the class it names (if not full) and can be returned by a later query; a zero address is discarded.
- R10: ref_rsp_ready is low exactly when ins_valid is high with ins_class equal to ref_rsp_class.
- R11: After reset every class is empty, rsp_valid is 0 and drop_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Dead-block insertion valid |
| ins_ready | output | 1 | Insertion ready, always 1 |
| ins_addr | input | ADDR_W | Address of the dead block |
| ins_class | input | CLS_W | Size class of the dead block |
| qry_valid | input | 1 | Reallocation query valid |
| qry_size | input | SIZE_W | Requested size in bytes |
| rsp_valid | output | 1 | Query answer valid, one cycle after the query |
| rsp_addr | output | ADDR_W | Reusable block address, 0 for none |
| ref_req_valid | output | 1 | Refill request to the next level |
| ref_req_ready | input | 1 | Next level accepts the request |
| ref_req_class | output | CLS_W | Class being refilled |
| ref_rsp_valid | input | 1 | Refill response valid |
| ref_rsp_ready | output | 1 | Refill response accepted |
| ref_rsp_class | input | CLS_W | Class of the returned block |
| ref_rsp_addr | input | ADDR_W | Returned block address, 0 for none |
| drop_count | output | DROP_W | Saturating count of discarded insertions |

## Verification
The checker assumes the next level answers only after it has taken a request and sends exactly one response per request; its single-outstanding property counts on that pairing. It also assumes the query response is consumed every cycle, since no ready exists on it. The directed tasks keep to this by raising ref_rsp_valid at a clock edge only after a request handshake, and by probing the response back-pressure with ref_rsp_valid pulses that are withdrawn before the next edge.

// File: rtl/rbt_pkg.sv
package rbt_pkg;
  typedef enum logic [1:0] {
    RF_IDLE = 2'd0,
    RF_ASK  = 2'd1,
    RF_WAIT = 2'd2
  } refill_state_e;
endpackage

// File: rtl/rbt_class_stack.sv
module rbt_class_stack #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  output logic [ADDR_W-1:0] pop_addr,
  output logic [CNT_W-1:0]  count,
  output logic              dropped
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] slots [DEPTH];
  logic              full, empty;
  logic [CNT_W-1:0]  cnt_m1;
  logic [IDX_W-1:0]  top_idx, wr_idx;

  always_comb begin
    full    = (count == CNT_W'(DEPTH));
    empty   = (count == '0);
    cnt_m1  = count - CNT_W'(1);
    top_idx = cnt_m1[IDX_W-1:0];
    wr_idx  = count[IDX_W-1:0];
    dropped = push && !pop && full;
    if (push && pop)
      pop_addr = push_addr;          // insertion first: bypass to the query
    else if (pop && !empty)
      pop_addr = slots[top_idx];
    else
      pop_addr = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (push && !pop && !full)
      count <= count + CNT_W'(1);
    else if (pop && !push && !empty)
      count <= cnt_m1;
  end

  always_ff @(posedge clk) begin
    if (push && !pop && !full)
      slots[wr_idx] <= push_addr;
  end
endmodule

// File: rtl/rbt_size_class.sv
module rbt_size_class #(
  parameter int SIZE_W      = 16,
  parameter int NUM_CLASSES = 4,
  parameter int MIN_BYTES   = 16,
  parameter int CLS_W       = 2
) (
  input  logic [SIZE_W-1:0] size,
  output logic [CLS_W-1:0]  cls,
  output logic              fits
);
  logic [NUM_CLASSES-1:0] fit_vec;

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_bound
    assign fit_vec[c] = (size <= SIZE_W'(MIN_BYTES << c));
  end

  always_comb begin
    cls = '0;
    for (int c = NUM_CLASSES - 1; c >= 0; c--)
      if (fit_vec[c]) cls = CLS_W'(c);
    fits = fit_vec[NUM_CLASSES-1];
  end
endmodule

// File: rtl/rbt_refill_ctrl.sv
module rbt_refill_ctrl
  import rbt_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int CLS_W       = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CLASSES-1:0] low_vec,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic [CLS_W-1:0]       req_class,
  input  logic                   rsp_fire
);
  refill_state_e    state_q;
  logic [CLS_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int c = NUM_CLASSES - 1; c >= 0; c--)
      if (low_vec[c]) pick = CLS_W'(c);
  end

  assign req_valid = (state_q == RF_ASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= RF_IDLE;
      req_class <= '0;
    end else begin
      unique case (state_q)
        RF_IDLE: if (|low_vec) begin
          req_class <= pick;
          state_q   <= RF_ASK;
        end
        RF_ASK:  if (req_ready) state_q <= RF_WAIT;
        RF_WAIT: if (rsp_fire)  state_q <= RF_IDLE;
        default: state_q <= RF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/reuse_block_table.sv
module reuse_block_table #(
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 16,
  parameter int NUM_CLASSES = 4,
  parameter int DEPTH       = 8,
  parameter int MIN_BYTES   = 16,
  parameter int REFILL_LOW  = 2,
  parameter int DROP_W      = 8,
  localparam int CLS_W      = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [CLS_W-1:0]  ins_class,
  input  logic              qry_valid,
  input  logic [SIZE_W-1:0] qry_size,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              ref_req_valid,
  input  logic              ref_req_ready,
  output logic [CLS_W-1:0]  ref_req_class,
  input  logic              ref_rsp_valid,
  output logic              ref_rsp_ready,
  input  logic [CLS_W-1:0]  ref_rsp_class,
  input  logic [ADDR_W-1:0] ref_rsp_addr,
  output logic [DROP_W-1:0] drop_count
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CLS_W-1:0]       q_cls;
  logic                   q_fits;
  logic                   rsp_fire, rsp_store, drop_hit;
  logic [NUM_CLASSES-1:0] push_v, pop_v, drop_v, low_v, ins_hit;
  logic [ADDR_W-1:0]      push_addr_c [NUM_CLASSES];
  logic [ADDR_W-1:0]      pop_addr_c  [NUM_CLASSES];
  logic [CNT_W-1:0]       cnt_c       [NUM_CLASSES];

  assign ins_ready     = 1'b1;
  assign ref_rsp_ready = !(ins_valid && (ins_class == ref_rsp_class));
  assign rsp_fire      = ref_rsp_valid && ref_rsp_ready;
  assign rsp_store     = rsp_fire && (ref_rsp_addr != '0);

  rbt_size_class #(
    .SIZE_W(SIZE_W), .NUM_CLASSES(NUM_CLASSES),
    .MIN_BYTES(MIN_BYTES), .CLS_W(CLS_W)
  ) sizer_i (
    .size(qry_size), .cls(q_cls), .fits(q_fits)
  );

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    assign ins_hit[c]     = ins_valid && (ins_class == CLS_W'(c));
    assign push_v[c]      = ins_hit[c] || (rsp_store && (ref_rsp_class == CLS_W'(c)));
    assign push_addr_c[c] = ins_hit[c] ? ins_addr : ref_rsp_addr;
    assign pop_v[c]       = qry_valid && q_fits && (q_cls == CLS_W'(c));
    assign low_v[c]       = (cnt_c[c] < CNT_W'(REFILL_LOW));

    rbt_class_stack #(
      .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
    ) stack_i (
      .clk(clk), .rst_n(rst_n),
      .push(push_v[c]), .push_addr(push_addr_c[c]),
      .pop(pop_v[c]), .pop_addr(pop_addr_c[c]),
      .count(cnt_c[c]), .dropped(drop_v[c])
    );
  end

  // a refill push never shares a class with an insertion, so a drop in an
  // inserted class belongs to the insertion
  assign drop_hit = |(drop_v & ins_hit);

  rbt_refill_ctrl #(
    .NUM_CLASSES(NUM_CLASSES), .CLS_W(CLS_W)
  ) refill_i (
    .clk(clk), .rst_n(rst_n), .low_vec(low_v),
    .req_valid(ref_req_valid), .req_ready(ref_req_ready),
    .req_class(ref_req_class), .rsp_fire(rsp_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_addr   <= '0;
      drop_count <= '0;
    end else begin
      rsp_valid <= qry_valid;
      rsp_addr  <= (qry_valid && q_fits) ? pop_addr_c[q_cls] : '0;
      if (drop_hit && (drop_count != '1))
        drop_count <= drop_count + DROP_W'(1);
    end
  end
endmodule

// File: rtl/rbt_checker.sv
module rbt_checker #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 16,
  parameter int CLS_W     = 2,
  parameter int DROP_W    = 8,
  parameter int MAX_BYTES = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_valid,
  input logic [CLS_W-1:0]  ins_class,
  input logic              qry_valid,
  input logic [SIZE_W-1:0] qry_size,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              ref_req_valid,
  input logic              ref_req_ready,
  input logic [CLS_W-1:0]  ref_req_class,
  input logic              ref_rsp_valid,
  input logic              ref_rsp_ready,
  input logic [CLS_W-1:0]  ref_rsp_class,
  input logic [DROP_W-1:0] drop_count
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n)
      outstanding <= 1'b0;
    else if (ref_req_valid && ref_req_ready)
      outstanding <= 1'b1;
    else if (ref_rsp_valid && ref_rsp_ready)
      outstanding <= 1'b0;
  end

  a_r1_rsp_follows_query: assert property (@(posedge clk) disable iff (!rst_n)
    qry_valid |=> rsp_valid);
  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !qry_valid |=> !rsp_valid);
  a_r3_oversize_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid && (qry_size > SIZE_W'(MAX_BYTES))) |=> (rsp_addr == '0));
  a_r6_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((drop_count == $past(drop_count)) ||
              (drop_count == $past(drop_count) + DROP_W'(1))));
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req_valid && !ref_req_ready) |=> (ref_req_valid && $stable(ref_req_class)));
  a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !ref_req_valid);
  a_r10_insert_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && (ins_class == ref_rsp_class)) |-> !ref_rsp_ready);
endmodule

bind reuse_block_table rbt_checker #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CLS_W(CLS_W), .DROP_W(DROP_W),
  .MAX_BYTES(MIN_BYTES << (NUM_CLASSES - 1))
) chk_i (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_class(ins_class),
  .qry_valid(qry_valid), .qry_size(qry_size), .rsp_valid(rsp_valid),
  .rsp_addr(rsp_addr), .ref_req_valid(ref_req_valid),
  .ref_req_ready(ref_req_ready), .ref_req_class(ref_req_class),
  .ref_rsp_valid(ref_rsp_valid), .ref_rsp_ready(ref_rsp_ready),
  .ref_rsp_class(ref_rsp_class), .drop_count(drop_count)
);

// File: tb/reuse_block_table_tb_top.sv
`timescale 1ns/1ps
module reuse_block_table_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ins_valid, ins_ready;
  logic [31:0] ins_addr;
  logic [1:0]  ins_class;
  logic        qry_valid;
  logic [15:0] qry_size;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic        ref_req_valid, ref_req_ready;
  logic [1:0]  ref_req_class;
  logic        ref_rsp_valid, ref_rsp_ready;
  logic [1:0]  ref_rsp_class;
  logic [31:0] ref_rsp_addr;
  logic [7:0]  drop_count;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  reuse_block_table dut_i (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_addr(ins_addr), .ins_class(ins_class),
    .qry_valid(qry_valid), .qry_size(qry_size), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .ref_req_valid(ref_req_valid), .ref_req_ready(ref_req_ready), .ref_req_class(ref_req_class),
    .ref_rsp_valid(ref_rsp_valid), .ref_rsp_ready(ref_rsp_ready),
    .ref_rsp_class(ref_rsp_class), .ref_rsp_addr(ref_rsp_addr),
    .drop_count(drop_count)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ins_valid = 0; ins_addr = 0; ins_class = 0;
    qry_valid = 0; qry_size = 0; ref_req_ready = 0;
    ref_rsp_valid = 0; ref_rsp_class = 0; ref_rsp_addr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic insert(input logic [1:0] c, input logic [31:0] a);
    ins_valid = 1; ins_class = c; ins_addr = a;
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic query_expect(input int size, input logic [31:0] exp, input string req);
    qry_valid = 1; qry_size = 16'(size);
    @(negedge clk);
    qry_valid = 0;
    check(rsp_valid == 1'b1, req, rsp_valid, 1);
    check(rsp_addr == exp, req, rsp_addr, exp);
  endtask

  task automatic t_reset();
    do_reset();
    check(rsp_valid == 0, "R11", rsp_valid, 0);
    check(drop_count == 0, "R11", drop_count, 0);
    check(ins_ready == 1, "R6", ins_ready, 1);
    check(ref_req_valid == 1 && ref_req_class == 0, "R7", {ref_req_valid, ref_req_class}, 3'b100);
    @(negedge clk);
    check(rsp_valid == 0, "R1", rsp_valid, 0);
    query_expect(16, 0, "R2");
    query_expect(33, 0, "R2");
    query_expect(128, 0, "R11");
  endtask

  task automatic t_rounding();
    do_reset();
    insert(0, 32'h100); insert(1, 32'h200); insert(2, 32'h300); insert(3, 32'h400);
    query_expect(17, 32'h200, "R1");
    query_expect(16, 32'h100, "R1");
    query_expect(64, 32'h300, "R1");
    query_expect(65, 32'h400, "R1");
    query_expect(1, 0, "R2");
  endtask

  task automatic t_oversize();
    do_reset();
    insert(3, 32'hA00);
    query_expect(129, 0, "R3");
    query_expect(4000, 0, "R3");
    query_expect(128, 32'hA00, "R3");
  endtask

  task automatic t_lifo();
    do_reset();
    insert(2, 32'h10); insert(2, 32'h20); insert(2, 32'h30);
    query_expect(50, 32'h30, "R4");
    query_expect(40, 32'h20, "R4");
    query_expect(60, 32'h10, "R4");
    query_expect(50, 0, "R4");
  endtask

  task automatic t_bypass();
    do_reset();
    ins_valid = 1; ins_class = 1; ins_addr = 32'h777;
    qry_valid = 1; qry_size = 32;
    @(negedge clk);
    ins_valid = 0; qry_valid = 0;
    check(rsp_addr == 32'h777, "R5", rsp_addr, 32'h777);
    query_expect(32, 0, "R5");
    insert(1, 32'h880);
    ins_valid = 1; ins_class = 1; ins_addr = 32'h990;
    qry_valid = 1; qry_size = 20;
    @(negedge clk);
    ins_valid = 0; qry_valid = 0;
    check(rsp_addr == 32'h990, "R5", rsp_addr, 32'h990);
    query_expect(20, 32'h880, "R5");
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < 8; i++) insert(1, 32'h1000 + 32'(i) * 32'h10);
    check(drop_count == 0, "R6", drop_count, 0);
    insert(1, 32'h9990);
    check(drop_count == 1, "R6", drop_count, 1);
    for (int i = 7; i >= 0; i--)
      query_expect(30, 32'h1000 + 32'(i) * 32'h10, "R6");
    query_expect(30, 0, "R6");
  endtask

  task automatic handshake_req(output logic [1:0] cls);
    cls = ref_req_class;
    ref_req_ready = 1;
    @(negedge clk);
    ref_req_ready = 0;
  endtask

  task automatic respond(input logic [1:0] c, input logic [31:0] a);
    ref_rsp_valid = 1; ref_rsp_class = c; ref_rsp_addr = a;
    @(negedge clk);
    ref_rsp_valid = 0;
  endtask

  task automatic t_refill();
    logic [1:0] cls;
    do_reset();
    for (int i = 0; i < 3; i++) begin
      check(ref_req_valid == 1 && ref_req_class == 0, "R7", ref_req_class, 0);
      @(negedge clk);
    end
    handshake_req(cls);
    for (int i = 0; i < 3; i++) begin
      check(ref_req_valid == 0, "R8", ref_req_valid, 0);
      @(negedge clk);
    end
    respond(cls, 32'h0);
    @(negedge clk);
    check(ref_req_valid == 1 && ref_req_class == 0, "R7", ref_req_class, 0);
    handshake_req(cls);
    respond(0, 32'h4440);
    @(negedge clk);
    check(ref_req_valid == 1 && ref_req_class == 0, "R7", ref_req_class, 0);
    handshake_req(cls);
    check(ref_req_valid == 0, "R8", ref_req_valid, 0);
    respond(0, 32'h4450);
    @(negedge clk);
    check(ref_req_valid == 1 && ref_req_class == 1, "R7", ref_req_class, 1);
    query_expect(16, 32'h4450, "R9");
    query_expect(10, 32'h4440, "R9");
    query_expect(16, 0, "R9");
  endtask

  task automatic t_rsp_ready();
    do_reset();
    ins_valid = 1; ins_class = 2; ins_addr = 32'h55;
    ref_rsp_valid = 1; ref_rsp_class = 2; ref_rsp_addr = 32'h123;
    #1;
    check(ref_rsp_ready == 0, "R10", ref_rsp_ready, 0);
    ref_rsp_class = 3;
    #1;
    check(ref_rsp_ready == 1, "R10", ref_rsp_ready, 1);
    ins_valid = 0; ref_rsp_valid = 0;
    #1;
    check(ref_rsp_ready == 1, "R10", ref_rsp_ready, 1);
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_rounding();
    t_oversize();
    t_lifo();
    t_bypass();
    t_full();
    t_refill();
    t_rsp_ready();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule